// File: doc/BRIEF.md
# Relocatable Peripheral Register Window Decoder

This block places a 4-Kbyte window of on-chip peripheral registers at any 4-Kbyte-aligned location of a 32-bit address map. It watches the processor bus (address, function code, read/write flag and strobe) and, when an ordinary access falls inside the window, raises a window-hit select together with the 12-bit byte offset into the window. Peripheral register banks use that offset to pick their own registers.

The window location lives in a base register. That register is reached only through a CPU-space access, with the function code at 4'b0111, at the one fixed address 0x0003_FF00. A write there moves the whole window at once. A read there returns the stored base and an enable bit. The window is disabled after reset, so no peripheral answers until software has placed the window and turned it on.

All decode results are registered. An access presented in one clock cycle yields its select, offset and read data on the outputs right after the next rising edge.

Top module: `periph_window_decoder`

## Requirements
- R1: After reset, `win_hit`, `win_offset`, `cfg_ack` and `cfg_rdata` are all zero, and a read of the base register returns 0, so the window is disabled.
- R2: A strobed access with a function code other than 4'b0111, while the window is enabled and with address bits [31:12] equal to the stored base, sets `win_hit` after the next rising edge. In the same cycle `win_offset` carries address bits [11:0].
- R3: The window covers exactly base to base+0xFFF. The byte at base-1 and the byte at base+0x1000 give no hit, while base+0x000 and base+0xFFF do give a hit.
- R4: The base register is selected, and `cfg_ack` is set after the next edge, only for a strobed access whose function code is 4'b0111 and whose address is 0x0003_FF00. The same address under any other function code leaves the register unchanged and is decoded as an ordinary access. A neighbouring address in CPU space selects nothing.
- R5: A write to the base register stores write-data bits [31:12] as the base and bit 0 as the enable bit. Bits [11:1] are ignored.
- R6: A read of the base register returns {base[31:12], 11'b0, enable} on `cfg_rdata` with `cfg_ack` set. `cfg_rdata` is zero in every other cycle, including after a base register write.
- R7: While the enable bit is 0, no access produces a window hit, whatever its address.
- R8: An access with function code 4'b0111 never produces a window hit, even when its address lies inside the window.
- R9: A base write takes effect for the very next access. An access in the following cycle decodes against the new base, and the old window no longer hits.
- R10: A cycle without the strobe produces neither a window hit nor a base register acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_strobe | input | 1 | A bus access is present this cycle |
| bus_fc | input | 4 | Function code of the access (4'b0111 = CPU space) |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data, used by base register writes |
| win_hit | output | 1 | Registered select: the previous access fell inside the window |
| win_offset | output | 12 | Byte offset in the window of that access, zero when no hit |
| cfg_ack | output | 1 | The previous access selected the base register |
| cfg_rdata | output | 32 | Base register read-back value, zero unless acknowledging a read |

## Verification
The hardest situation to reach is the overlap case. Here the window has been placed over the page holding 0x0003_FF00, so the fixed register address is both a window byte and the base register, told apart only by the function code. The stimulus first relocates the window onto that page. It then sends the same address under several non-CPU function codes (expecting window hits at offset 0xF00), a CPU-space read (expecting an acknowledge and no hit), and a non-CPU write whose data would have disabled the window. A read-back follows to show that this write left the base untouched. Back-to-back relocation followed at once by an access shows that decoding uses the new base on the very next cycle.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    // Classification of one bus cycle after decode.
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_CFG_RD = 2'd1,
        ACC_CFG_WR = 2'd2,
        ACC_WINDOW = 2'd3
    } acc_kind_e;

    localparam logic [3:0] FC_CPU_SPACE = 4'b0111;

endpackage

// File: rtl/pwd_cfg_decode.sv
// Detects accesses to the base register and CPU-space cycles.
module pwd_cfg_decode #(
    parameter int              ADDR_W   = 32,
    parameter int              FC_W     = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h0003_FF00,
    parameter logic [FC_W-1:0]   CPU_FC   = 4'b0111
) (
    input  logic              strobe,
    input  logic [FC_W-1:0]   fc,
    input  logic [ADDR_W-1:0] addr,
    output logic              cpu_space,
    output logic              cfg_sel
);

    always_comb begin
        cpu_space = strobe && (fc == CPU_FC);
        cfg_sel   = cpu_space && (addr == CFG_ADDR);
    end

endmodule

// File: rtl/pwd_win_match.sv
// Compares the page bits of an address against the programmed base page.
module pwd_win_match #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 12,
    localparam int PAGE_W  = ADDR_W - WIN_BITS
) (
    input  logic                en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PAGE_W-1:0]   base_page,
    output logic                hit,
    output logic [WIN_BITS-1:0] offset
);

    logic [PAGE_W-1:0] bit_eq;

    // Per-bit equality, reduced afterwards.
    for (genvar gi = 0; gi < PAGE_W; gi++) begin : g_eq
        assign bit_eq[gi] = ~(addr[WIN_BITS+gi] ^ base_page[gi]);
    end

    always_comb begin
        hit    = en && (&bit_eq);
        offset = hit ? addr[WIN_BITS-1:0] : '0;
    end

endmodule

// File: rtl/pwd_readback.sv
// Builds the base register read-back word: page field, zero gap, enable bit.
module pwd_readback #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 12,
    localparam int PAGE_W  = ADDR_W - WIN_BITS
) (
    input  logic [PAGE_W-1:0] base_page,
    input  logic              enable,
    output logic [ADDR_W-1:0] word
);

    for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_bit
        if (gi >= WIN_BITS) begin : g_page
            assign word[gi] = base_page[gi-WIN_BITS];
        end else if (gi == 0) begin : g_en
            assign word[gi] = enable;
        end else begin : g_gap
            assign word[gi] = 1'b0;
        end
    end

endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder #(
    parameter int                ADDR_W   = 32,
    parameter int                FC_W     = 4,
    parameter int                WIN_BITS = 12,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h0003_FF00,
    parameter logic [FC_W-1:0]   CPU_FC   = pwd_pkg::FC_CPU_SPACE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_strobe,
    input  logic [FC_W-1:0]     bus_fc,
    input  logic                bus_read,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [ADDR_W-1:0]   bus_wdata,
    output logic                win_hit,
    output logic [WIN_BITS-1:0] win_offset,
    output logic                cfg_ack,
    output logic [ADDR_W-1:0]   cfg_rdata
);

    import pwd_pkg::*;

    localparam int PAGE_W = ADDR_W - WIN_BITS;

    typedef struct packed {
        logic [PAGE_W-1:0]   base_page;
        logic                enable;
        logic                hit;
        logic [WIN_BITS-1:0] offset;
        logic                ack;
        logic [ADDR_W-1:0]   rdata;
    } state_t;

    state_t state_d, state_q;

    logic                cpu_space;
    logic                cfg_sel;
    logic                match_hit;
    logic [WIN_BITS-1:0] match_off;
    logic [ADDR_W-1:0]   rb_word;
    acc_kind_e           kind;

    pwd_cfg_decode #(
        .ADDR_W  (ADDR_W),
        .FC_W    (FC_W),
        .CFG_ADDR(CFG_ADDR),
        .CPU_FC  (CPU_FC)
    ) u_cfg (
        .strobe   (bus_strobe),
        .fc       (bus_fc),
        .addr     (bus_addr),
        .cpu_space(cpu_space),
        .cfg_sel  (cfg_sel)
    );

    // Window decode is gated by strobe, enable bit and non-CPU-space cycles.
    pwd_win_match #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS)
    ) u_match (
        .en       (bus_strobe && state_q.enable && !cpu_space),
        .addr     (bus_addr),
        .base_page(state_q.base_page),
        .hit      (match_hit),
        .offset   (match_off)
    );

    pwd_readback #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS)
    ) u_rb (
        .base_page(state_q.base_page),
        .enable   (state_q.enable),
        .word     (rb_word)
    );

    always_comb begin
        if (cfg_sel)        kind = bus_read ? ACC_CFG_RD : ACC_CFG_WR;
        else if (match_hit) kind = ACC_WINDOW;
        else                kind = ACC_IDLE;
    end

    always_comb begin
        state_d        = state_q;
        state_d.hit    = 1'b0;
        state_d.offset = '0;
        state_d.ack    = 1'b0;
        state_d.rdata  = '0;
        unique case (kind)
            ACC_CFG_RD: begin
                state_d.ack   = 1'b1;
                state_d.rdata = rb_word;
            end
            ACC_CFG_WR: begin
                state_d.ack       = 1'b1;
                state_d.base_page = bus_wdata[ADDR_W-1:WIN_BITS];
                state_d.enable    = bus_wdata[0];
            end
            ACC_WINDOW: begin
                state_d.hit    = 1'b1;
                state_d.offset = match_off;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign win_hit    = state_q.hit;
    assign win_offset = state_q.offset;
    assign cfg_ack    = state_q.ack;
    assign cfg_rdata  = state_q.rdata;

    // Observation points for the bound checker.
    logic              enable_now;
    logic [PAGE_W-1:0] page_now;
    assign enable_now = state_q.enable;
    assign page_now   = state_q.base_page;

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
    parameter int                ADDR_W   = 32,
    parameter int                FC_W     = 4,
    parameter int                WIN_BITS = 12,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h0003_FF00,
    parameter logic [FC_W-1:0]   CPU_FC   = 4'b0111,
    localparam int               PAGE_W   = ADDR_W - WIN_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_strobe,
    input logic [FC_W-1:0]     bus_fc,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                win_hit,
    input logic [WIN_BITS-1:0] win_offset,
    input logic                cfg_ack,
    input logic [ADDR_W-1:0]   cfg_rdata,
    input logic                enable_now,
    input logic [PAGE_W-1:0]   page_now
);

    a_r2_offset_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (win_offset == $past(bus_addr[WIN_BITS-1:0]))
                 && ($past(bus_addr[ADDR_W-1:WIN_BITS]) == $past(page_now)));

    a_r4_ack_only_fixed_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |-> $past(bus_strobe) && ($past(bus_fc) == CPU_FC)
                 && ($past(bus_addr) == CFG_ADDR));

    a_r6_rdata_zero_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ack |-> (cfg_rdata == '0));

    a_r6_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[WIN_BITS-1:1] == '0);

    a_r7_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> $past(enable_now));

    a_r8_cpu_space_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_strobe) && ($past(bus_fc) == CPU_FC)) |-> !win_hit);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_strobe) |-> !win_hit && !cfg_ack);

    a_r1_offset_zero_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (win_offset == '0));

endmodule

bind periph_window_decoder pwd_checker #(
    .ADDR_W  (ADDR_W),
    .FC_W    (FC_W),
    .WIN_BITS(WIN_BITS),
    .CFG_ADDR(CFG_ADDR),
    .CPU_FC  (CPU_FC)
) u_pwd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_strobe(bus_strobe),
    .bus_fc    (bus_fc),
    .bus_addr  (bus_addr),
    .win_hit   (win_hit),
    .win_offset(win_offset),
    .cfg_ack   (cfg_ack),
    .cfg_rdata (cfg_rdata),
    .enable_now(enable_now),
    .page_now  (page_now)
);

// File: tb/periph_window_decoder_bench.sv
`timescale 1ns/1ps
module periph_window_decoder_bench;

    localparam logic [31:0] CFG = 32'h0003_FF00;

    typedef struct packed {
        logic        hit;
        logic [11:0] off;
        logic        ack;
        logic [31:0] rdata;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_strobe = 1'b0;
    logic [3:0]  bus_fc = 4'd0;
    logic        bus_read = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        win_hit;
    logic [11:0] win_offset;
    logic        cfg_ack;
    logic [31:0] cfg_rdata;

    int compared = 0;
    int mismatched = 0;

    exp_t  exp_q[$];
    string req_q[$];

    // Reference model state.
    logic [19:0] m_page = '0;
    logic        m_en   = 1'b0;
    logic        driving = 1'b0;

    always #2.5 clk = ~clk;

    periph_window_decoder u_periph_window_decoder (
        .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_fc(bus_fc),
        .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .win_hit(win_hit), .win_offset(win_offset), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    // Driver: present one bus cycle and push its expected result.
    task automatic bus(input string req, input logic stb, input logic [3:0] fc,
                       input logic rd, input logic [31:0] addr, input logic [31:0] wd);
        exp_t e;
        logic sel, hit;
        @(negedge clk);
        bus_strobe = stb; bus_fc = fc; bus_read = rd; bus_addr = addr; bus_wdata = wd;
        sel = stb && fc == 4'b0111 && addr == CFG;
        hit = stb && m_en && fc != 4'b0111 && addr[31:12] == m_page;
        e.hit   = hit;
        e.off   = hit ? addr[11:0] : 12'h000;
        e.ack   = sel;
        e.rdata = (sel && rd) ? {m_page, 11'b0, m_en} : 32'h0;
        exp_q.push_back(e);
        req_q.push_back(req);
        if (sel && !rd) begin
            m_page = wd[31:12];
            m_en   = wd[0];
        end
    endtask

    task automatic idle(input string req);
        bus(req, 1'b0, 4'd5, 1'b1, 32'h1234_5000, 32'h0);
    endtask

    task automatic set_base(input string req, input logic [31:0] v);
        bus(req, 1'b1, 4'b0111, 1'b0, CFG, v);
    endtask

    task automatic get_base(input string req);
        bus(req, 1'b1, 4'b0111, 1'b1, CFG, 32'h0);
    endtask

    task automatic acc(input string req, input logic [3:0] fc, input logic [31:0] a);
        bus(req, 1'b1, fc, 1'b1, a, 32'h0);
    endtask

    // Monitor: compare registered outputs just after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            compared++;
            if (win_hit !== e.hit || win_offset !== e.off ||
                cfg_ack !== e.ack || cfg_rdata !== e.rdata) begin
                mismatched++;
                $display("FAIL %s: got hit=%b off=%h ack=%b rdata=%h, expected hit=%b off=%h ack=%b rdata=%h",
                         r, win_hit, win_offset, cfg_ack, cfg_rdata,
                         e.hit, e.off, e.ack, e.rdata);
            end
        end
    end

    initial begin
        #200000;
        mismatched++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during and right after reset
        compared++;
        if (win_hit !== 1'b0 || cfg_ack !== 1'b0 || cfg_rdata !== 32'h0 || win_offset !== 12'h0) begin
            mismatched++;
            $display("FAIL R1: got hit=%b ack=%b rdata=%h, expected all zero", win_hit, cfg_ack, cfg_rdata);
        end
        rst_n = 1'b1;
        idle("R1");
        get_base("R1");
        acc("R7", 4'd5, 32'h0000_0010);
        acc("R7", 4'd5, 32'h0000_0000);

        // R5: low bits ignored, bit 0 enables
        set_base("R5", 32'h1234_5FFF);
        get_base("R6");
        acc("R3", 4'd5, 32'h1234_5000);
        acc("R3", 4'd5, 32'h1234_5FFF);
        acc("R3", 4'd5, 32'h1234_4FFF);
        acc("R3", 4'd5, 32'h1234_6000);
        acc("R2", 4'd1, 32'h1234_5A5C);
        acc("R8", 4'b0111, 32'h1234_5100);
        bus("R10", 1'b0, 4'd5, 1'b1, 32'h1234_5200, 32'h0);
        bus("R2", 1'b1, 4'd2, 1'b0, 32'h1234_5004, 32'hDEAD_BEEF);

        // R9: relocate onto the page of the fixed register, access at once
        set_base("R9", 32'h0003_F001);
        acc("R9", 4'd5, 32'h0003_F800);
        acc("R9", 4'd5, 32'h1234_5000);
        acc("R4", 4'd5, CFG);
        acc("R4", 4'd6, CFG);
        get_base("R4");
        acc("R4", 4'b0111, 32'h0003_FF04);
        bus("R4", 1'b1, 4'd5, 1'b0, CFG, 32'h0000_0000);
        get_base("R4");
        bus("R10", 1'b0, 4'b0111, 1'b0, CFG, 32'h0000_0000);
        get_base("R10");

        // Top of the address map
        set_base("R9", 32'hFFFF_F001);
        acc("R3", 4'd5, 32'hFFFF_EFFF);
        acc("R3", 4'd5, 32'hFFFF_F000);
        acc("R3", 4'd5, 32'hFFFF_FFFF);

        // Bottom of the address map
        set_base("R5", 32'h0000_0003);
        acc("R3", 4'd5, 32'h0000_0FFF);
        acc("R3", 4'd5, 32'h0000_1000);
        get_base("R6");

        // R7: disable keeps the base
        set_base("R7", 32'h8000_0000);
        acc("R7", 4'd5, 32'h8000_0000);
        acc("R7", 4'd5, 32'h8000_0FFF);
        get_base("R7");
        set_base("R7", 32'h8000_0001);
        acc("R7", 4'd5, 32'h8000_0ABC);
        idle("R10");
        idle("R10");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule